// File: doc/BRIEF.md
# Fixed-Point Source Position Stepper

This block produces the source framebuffer coordinate that a resampling scaler reads for every output pixel and every output line. Each axis keeps a position accumulator in unsigned fixed point with ten fraction bits. The horizontal position restarts from its offset at the start of each line and moves forward by the horizontal step for every output sample. The vertical position restarts from its offset at the start of each frame and moves forward by the vertical step for every new line.

For each axis the block presents the integer source index and a coarse fractional weight, ready for an interpolator. It also raises a flag when the horizontal step is larger than the fetch budget allows for the selected pixel depth. Pixel storage, the interpolation itself and fetch arbitration live elsewhere.

Top module: `srcpos_stepper`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, every index and weight output is 0.
- R2: In each axis configuration word, bits 27:16 hold the start offset and bits 11:0 hold the step. Bits 31:28 and 15:12 have no effect on any output.
- R3: Positions are unsigned with 10 fraction bits, so a step of 0x400 moves by exactly one source pixel. The index output is the accumulator shifted right by 10. The weight output is accumulator bits 9:5.
- R4: A line-start strobe loads the horizontal accumulator with the horizontal offset, and the outputs show it one clock edge later.
- R5: A sample-advance strobe adds the horizontal step to the horizontal accumulator. If a line-start strobe arrives in the same cycle, the load wins and the step is not added.
- R6: A frame-start strobe loads both accumulators with their offsets. It takes priority over a line-start or sample-advance strobe in the same cycle.
- R7: A line-start strobe without a frame-start strobe adds the vertical step to the vertical accumulator. A sample-advance strobe leaves the vertical outputs unchanged.
- R8: The accumulator saturates at 2^23-1 (index 8191, weight 31) instead of wrapping.
- R9: The step-limit flag is combinational. When the wide-pixel input is 1 (32-bit pixels), the flag is 1 if the horizontal step exceeds 0x800. When it is 0 (16-bit pixels), the flag is 1 if the step exceeds 0xE00.
- R10: A line of 1024 samples at the largest step, 0xFFF, starting from the largest offset, never reaches saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cfg_i | input | 32 | Horizontal offset and step word |
| v_cfg_i | input | 32 | Vertical offset and step word |
| wide_pix_i | input | 1 | 1 = 32-bit pixels, 0 = 16-bit pixels |
| frame_start_i | input | 1 | Start-of-frame strobe |
| line_start_i | input | 1 | Start-of-line strobe |
| sample_adv_i | input | 1 | Per-output-sample advance strobe |
| h_index_o | output | 13 | Horizontal integer source index |
| h_weight_o | output | 5 | Horizontal fractional weight |
| v_index_o | output | 13 | Vertical integer source index |
| v_weight_o | output | 5 | Vertical fractional weight |
| h_step_bad_o | output | 1 | Horizontal step exceeds the fetch budget |

## Verification
The bench drives line-start and sample-advance in the same cycle. A design that lets the advance win there starts every line one step late. It also sends frame-start together with line-start, which catches a vertical axis that both loads and steps on the first line.

The bench places stray bits in the unused nibbles of the configuration words to expose a decoder that reads the wrong field. It also walks the step-limit flag exactly at 0x800 and 0xE00, and one above each, where an off-by-one comparison flips the flag.

A run of more than 2048 maximum steps pushes the accumulator into saturation. A wrapping design would drop back to a small index there. The bench then checks that a full 1024-sample line at the worst step and offset stays below that point.

// File: rtl/srcpos_pkg.sv
package srcpos_pkg;
   // fixed-point format of step and offset
   localparam int unsigned FIX_W  = 12;
   localparam int unsigned FRAC_W = 10;
   // field placement inside an axis configuration word
   localparam int unsigned OFS_LSB = 16;
   localparam int unsigned STP_LSB = 0;

   typedef struct packed {
      logic [FIX_W-1:0] offset;
      logic [FIX_W-1:0] step;
   } axis_cfg_t;

   function automatic axis_cfg_t split_cfg(input logic [31:0] word);
      axis_cfg_t c;
      c.offset = word[OFS_LSB +: FIX_W];
      c.step   = word[STP_LSB +: FIX_W];
      return c;
   endfunction
endpackage

// File: rtl/srcpos_axis_acc.sv
module srcpos_axis_acc #(
   parameter int unsigned FIX_W    = 12,
   parameter int unsigned ACC_W    = 23,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [FIX_W-1:0] offset_i,
   input  logic [FIX_W-1:0] step_i,
   output logic [ACC_W-1:0] acc_o
);
   localparam int unsigned PAD_W = ACC_W - FIX_W;

   if (ACC_W <= FIX_W) begin : g_bad_width
      $error("srcpos_axis_acc: ACC_W must exceed FIX_W");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum_w;
   logic [ACC_W-1:0] adv_val;
   logic [ACC_W-1:0] load_val;

   assign sum_w    = {1'b0, acc_q} + {{(PAD_W + 1){1'b0}}, step_i};
   assign load_val = {{PAD_W{1'b0}}, offset_i};

   if (SATURATE) begin : g_sat
      assign adv_val = sum_w[ACC_W] ? {ACC_W{1'b1}} : sum_w[ACC_W-1:0];
   end else begin : g_wrap
      assign adv_val = sum_w[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (load_i) acc_q <= load_val;
      else if (adv_i)  acc_q <= adv_val;
   end

   assign acc_o = acc_q;

   AST_LOAD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (acc_q == {{PAD_W{1'b0}}, $past(offset_i)}));   // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(acc_q));                   // R7
   if (SATURATE) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (adv_i && !load_i) |=> (acc_q >= $past(acc_q)));         // R8
   end
endmodule

// File: rtl/srcpos_pos_split.sv
module srcpos_pos_split #(
   parameter int unsigned ACC_W  = 23,
   parameter int unsigned FRAC_W = 10,
   parameter int unsigned WGT_W  = 5
) (
   input  logic [ACC_W-1:0]        acc_i,
   output logic [ACC_W-FRAC_W-1:0] index_o,
   output logic [WGT_W-1:0]        weight_o
);
   if (WGT_W > FRAC_W || WGT_W == 0) begin : g_bad_wgt
      $error("srcpos_pos_split: WGT_W must be 1..FRAC_W");
   end

   assign index_o = acc_i[ACC_W-1:FRAC_W];

   if (WGT_W == FRAC_W) begin : g_full
      assign weight_o = acc_i[FRAC_W-1:0];
   end else begin : g_trunc
      assign weight_o = acc_i[FRAC_W-1 -: WGT_W];
   end
endmodule

// File: rtl/srcpos_step_check.sv
module srcpos_step_check #(
   parameter int unsigned      FIX_W      = 12,
   parameter logic [FIX_W-1:0] LIM_WIDE   = 12'h800,
   parameter logic [FIX_W-1:0] LIM_NARROW = 12'hE00
) (
   input  logic [FIX_W-1:0] step_i,
   input  logic             wide_i,
   output logic             bad_o
);
   logic [FIX_W-1:0] limit;
   assign limit = wide_i ? LIM_WIDE : LIM_NARROW;
   assign bad_o = (step_i > limit);
endmodule

// File: rtl/srcpos_stepper.sv
module srcpos_stepper #(
   parameter int unsigned MAX_SAMPLES = 1024,
   parameter int unsigned WGT_W       = 5,
   parameter bit          SATURATE    = 1'b1,
   parameter logic [11:0] LIM_WIDE    = 12'h800,
   parameter logic [11:0] LIM_NARROW  = 12'hE00,
   localparam int unsigned FIX_W  = srcpos_pkg::FIX_W,
   localparam int unsigned FRAC_W = srcpos_pkg::FRAC_W,
   localparam int unsigned CNT_W  = $clog2(MAX_SAMPLES + 1),
   localparam int unsigned ACC_W  = FIX_W + CNT_W,
   localparam int unsigned IDX_W  = ACC_W - FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      h_cfg_i,
   input  logic [31:0]      v_cfg_i,
   input  logic             wide_pix_i,
   input  logic             frame_start_i,
   input  logic             line_start_i,
   input  logic             sample_adv_i,
   output logic [IDX_W-1:0] h_index_o,
   output logic [WGT_W-1:0] h_weight_o,
   output logic [IDX_W-1:0] v_index_o,
   output logic [WGT_W-1:0] v_weight_o,
   output logic             h_step_bad_o
);
   import srcpos_pkg::*;

   if (MAX_SAMPLES < 2) begin : g_bad_samples
      $error("srcpos_stepper: MAX_SAMPLES must be at least 2");
   end

   axis_cfg_t h_cfg, v_cfg;
   assign h_cfg = split_cfg(h_cfg_i);
   assign v_cfg = split_cfg(v_cfg_i);

   // per-axis control: index 0 horizontal, index 1 vertical
   logic [1:0] load_w, adv_w;
   assign load_w[0] = frame_start_i | line_start_i;
   assign adv_w[0]  = sample_adv_i;
   assign load_w[1] = frame_start_i;
   assign adv_w[1]  = line_start_i;

   logic [1:0][FIX_W-1:0] offs_w, step_w;
   assign offs_w[0] = h_cfg.offset;
   assign step_w[0] = h_cfg.step;
   assign offs_w[1] = v_cfg.offset;
   assign step_w[1] = v_cfg.step;

   logic [1:0][ACC_W-1:0] acc_w;
   logic [1:0][IDX_W-1:0] idx_w;
   logic [1:0][WGT_W-1:0] wgt_w;

   for (genvar a = 0; a < 2; a++) begin : g_axis
      srcpos_axis_acc #(
         .FIX_W(FIX_W), .ACC_W(ACC_W), .SATURATE(SATURATE)
      ) i_acc (
         .clk(clk), .rst_n(rst_n),
         .load_i(load_w[a]), .adv_i(adv_w[a]),
         .offset_i(offs_w[a]), .step_i(step_w[a]),
         .acc_o(acc_w[a])
      );
      srcpos_pos_split #(
         .ACC_W(ACC_W), .FRAC_W(FRAC_W), .WGT_W(WGT_W)
      ) i_split (
         .acc_i(acc_w[a]), .index_o(idx_w[a]), .weight_o(wgt_w[a])
      );
   end

   srcpos_step_check #(
      .FIX_W(FIX_W), .LIM_WIDE(LIM_WIDE), .LIM_NARROW(LIM_NARROW)
   ) i_chk (
      .step_i(h_cfg.step), .wide_i(wide_pix_i), .bad_o(h_step_bad_o)
   );

   assign h_index_o  = idx_w[0];
   assign h_weight_o = wgt_w[0];
   assign v_index_o  = idx_w[1];
   assign v_weight_o = wgt_w[1];

   AST_V_IGNORES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_adv_i && !line_start_i && !frame_start_i)
      |=> ($stable(v_index_o) && $stable(v_weight_o)));          // R7
   AST_LINE_BEATS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start_i && sample_adv_i && !frame_start_i)
      |=> (h_index_o == IDX_W'($past(h_cfg.offset) >> FRAC_W)));  // R5
   AST_FRAME_LOADS_V: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_i |=> (v_index_o == IDX_W'($past(v_cfg.offset) >> FRAC_W))); // R6
   AST_WIDE_LIMIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_pix_i && h_cfg.step <= LIM_WIDE) |-> !h_step_bad_o);  // R9
endmodule

// File: tb/test_srcpos_stepper.sv
module test_srcpos_stepper;
   localparam longint MAXACC = (64'd1 << 23) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] h_cfg_i = '0, v_cfg_i = '0;
   logic        wide_pix_i = 1'b0;
   logic        frame_start_i = 1'b0, line_start_i = 1'b0, sample_adv_i = 1'b0;
   logic [12:0] h_index_o, v_index_o;
   logic [4:0]  h_weight_o, v_weight_o;
   logic        h_step_bad_o;

   always #10 clk = ~clk;

   srcpos_stepper i_srcpos_stepper (
      .clk(clk), .rst_n(rst_n), .h_cfg_i(h_cfg_i), .v_cfg_i(v_cfg_i),
      .wide_pix_i(wide_pix_i), .frame_start_i(frame_start_i),
      .line_start_i(line_start_i), .sample_adv_i(sample_adv_i),
      .h_index_o(h_index_o), .h_weight_o(h_weight_o),
      .v_index_o(v_index_o), .v_weight_o(v_weight_o),
      .h_step_bad_o(h_step_bad_o)
   );

   int     n_tot = 0, n_fail = 0;
   bit     done = 1'b0;
   longint h_acc = 0, v_acc = 0;
   longint h_off = 0, h_stp = 0, v_off = 0, v_stp = 0;

   function automatic longint sat_add(longint a, longint b);
      return (a + b > MAXACC) ? MAXACC : a + b;
   endfunction

   function automatic longint pos_code(longint acc);
      return ((acc >> 10) << 5) | ((acc >> 5) & 31);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_tot++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_pos(string req);
      chk({req, " h"}, {h_index_o, h_weight_o}, pos_code(h_acc));
      chk({req, " v"}, {v_index_o, v_weight_o}, pos_code(v_acc));
   endtask

   // stray bits land in 31:28 and 15:12 (R2)
   task automatic set_cfg(longint ho, longint hs, longint vo, longint vs, bit [3:0] junk);
      h_off = ho; h_stp = hs; v_off = vo; v_stp = vs;
      h_cfg_i = {junk, 12'(ho), junk, 12'(hs)};
      v_cfg_i = {junk, 12'(vo), junk, 12'(vs)};
   endtask

   // called at a negedge; returns at the next negedge
   task automatic cyc(bit fs, bit ls, bit adv);
      frame_start_i = fs; line_start_i = ls; sample_adv_i = adv;
      if (fs) begin
         h_acc = h_off; v_acc = v_off;
      end else if (ls) begin
         h_acc = h_off; v_acc = sat_add(v_acc, v_stp);
      end else if (adv) begin
         h_acc = sat_add(h_acc, h_stp);
      end
      @(negedge clk);
      frame_start_i = 0; line_start_i = 0; sample_adv_i = 0;
   endtask

   task automatic chk_flag(bit wide, longint stp, bit exp);
      wide_pix_i = wide;
      h_cfg_i[11:0] = 12'(stp);
      #1;
      chk("R9 step flag", h_step_bad_o, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tot++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      set_cfg(12'h155, 12'h400, 12'hC00, 12'h300, 4'hF);
      chk_pos("R1 reset held");
      rst_n = 1'b1;
      @(negedge clk);
      chk_pos("R1 after reset");

      // R6 frame start loads both offsets, beats line start; R2 junk ignored
      cyc(1, 1, 1); chk_pos("R6 frame load / R2 fields");
      chk("R3 offset 0xC00 index", v_index_o, 3);
      chk("R3 offset 0x155 weight", h_weight_o, 10);
      // R3/R5 unit step moves exactly one source pixel
      cyc(0, 0, 1); chk_pos("R5 advance");
      chk("R3 unit step index", h_index_o, 1);
      cyc(0, 0, 1); chk_pos("R5 advance 2");
      cyc(0, 0, 0); chk_pos("R5 idle hold");
      // R7 sample advance leaves vertical alone
      chk("R7 v unchanged", v_index_o, 3);
      // R4/R5 line start beats advance; R7 vertical steps
      cyc(0, 1, 1); chk_pos("R4 R5 line reload priority");
      chk("R7 v step", {v_index_o, v_weight_o}, pos_code(64'hF00));

      // R9 thresholds
      chk_flag(1, 12'h800, 0);
      chk_flag(1, 12'h801, 1);
      chk_flag(0, 12'h801, 0);
      chk_flag(0, 12'hE00, 0);
      chk_flag(0, 12'hE01, 1);
      chk_flag(1, 12'hFFF, 1);

      // R10 worst-case full line stays exact
      set_cfg(12'hFFF, 12'hFFF, 0, 0, 4'h0);
      cyc(0, 1, 0);
      for (int i = 0; i < 1024; i++) cyc(0, 0, 1);
      chk_pos("R10 full line no saturation");
      chk("R10 exact end", {h_index_o, h_weight_o}, pos_code(64'hFFF * 1025));

      // R8 saturation
      set_cfg(0, 12'hFFF, 0, 0, 4'h0);
      cyc(0, 1, 0);
      for (int i = 0; i < 2060; i++) cyc(0, 0, 1);
      chk("R8 saturated index", h_index_o, 8191);
      chk("R8 saturated weight", h_weight_o, 31);

      // random frames against the integer model
      for (int f = 0; f < 6; f++) begin
         set_cfg($urandom_range(0, 4095), $urandom_range(0, 4095),
                 $urandom_range(0, 4095), $urandom_range(0, 4095),
                 4'($urandom_range(0, 15)));
         cyc(1, 0, 0); chk_pos("R6 random frame");
         for (int l = 0; l < 3; l++) begin
            cyc(0, 1, 0); chk_pos("R4 R7 random line");
            for (int s = 0; s < $urandom_range(1, 1024); s++) begin
               cyc(0, 0, ($urandom_range(0, 3) != 0));
               chk_pos("R3 R5 random sample");
            end
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   end
endmodule